// File: doc/BRIEF.md
# Timer capture unit with event prescaler

The block watches one external input pin and, when a selected event occurs on it, copies the current value of a free-running 16-bit timer into a capture register. A 4-bit mode field chooses the event (each falling edge, each rising edge, each 4th rising edge or each 16th rising edge) or parks the unit in a non-capture state. Each capture raises a sticky interrupt flag. Software clears the flag with a one-cycle clear strobe.

The pin is asynchronous. It passes through a two-flop synchronizer, and a third flop keeps the previous synchronized sample for edge detection. The rising-edge prescaler keeps its count when software moves directly from one capture code to another, so the first capture after such a switch can come early. Any non-capture code clears the count. A direct change from one capture code to a different capture code also fires one spurious capture and sets the flag. Entering a capture code from a non-capture code does not.

Top module: `tmr_capture_unit`

## Requirements
- R1: After reset the capture register is 0, the flag is 0 and the prescaler count is 0.
- R2: With mode 4'b0100, each falling edge of the pin copies `timer_val` into `cap_value` at the third rising clock edge after the pin changes. Rising edges do not capture.
- R3: With mode 4'b0101, each rising edge of the pin captures with the same 3-cycle latency. Falling edges do not capture.
- R4: With mode 4'b0110 and the count starting at 0, the 4th rising edge captures and the first three do not.
- R5: With mode 4'b0111 and the count starting at 0, the 16th rising edge captures and the first fifteen do not.
- R6: Codes other than 4'b0100 to 4'b0111 (4'b0000 is off) never capture, and they clear the prescaler count.
- R7: A direct switch between 4'b0111 and 4'b0110 keeps the prescaler count, which counts modulo 16. After 6 rising edges under 4'b0111, the 2nd rising edge under 4'b0110 captures.
- R8: Every capture sets `cap_flag`. The flag stays set until a `flag_clr` pulse, which clears it one edge later.
- R9: When `flag_clr` and a capture fall on the same clock edge, the flag stays set.
- R10: A capture while the flag is still set overwrites `cap_value` with the new timer value.
- R11: A direct change from one capture code to a different capture code captures `timer_val` and sets the flag at the first clock edge that sees the new code. Changing from a non-capture code into a capture code does not capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | Asynchronous event pin |
| timer_val | input | 16 | Current free-running timer value |
| mode | input | 4 | Event select and on/off code |
| flag_clr | input | 1 | One-cycle flag clear strobe |
| cap_value | output | 16 | Captured timer value |
| cap_flag | output | 1 | Sticky capture flag |

## Verification
A pin event reaches `cap_value` and `cap_flag` at the third rising clock edge after the pin changes: two edges pass through the synchronizer and one edge registers the result. The bench therefore drives the pin on a falling clock edge and samples three falling edges later. For latency it also checks that nothing has happened one edge earlier. A spurious capture after a mode change, a flag clear and a clear that collides with a capture all take effect at the next rising edge, so those checks sample at the following falling edge. Prescaler checks count whole pin pulses and look just before and just after the pulse that should capture.

// File: rtl/tmr_capture_unit.sv
module tmr_capture_unit #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin_in,
  input  logic [TW-1:0] timer_val,
  input  logic [3:0]    mode,
  input  logic          flag_clr,
  output logic [TW-1:0] cap_value,
  output logic          cap_flag
);

  localparam logic [3:0] M_FALL  = 4'b0100;
  localparam logic [3:0] M_RISE  = 4'b0101;
  localparam logic [3:0] M_DIV4  = 4'b0110;
  localparam logic [3:0] M_DIV16 = 4'b0111;

  logic [2:0] sync_q;
  logic [3:0] mode_q;
  logic [3:0] cnt;
  logic       evt;

  wire rise     = sync_q[1] & ~sync_q[2];
  wire fall     = ~sync_q[1] & sync_q[2];
  wire cap_on   = (mode[3:2] == 2'b01);
  wire cap_on_q = (mode_q[3:2] == 2'b01);
  wire mode_chg = cap_on && cap_on_q && (mode != mode_q);
  wire prescaled = (mode == M_DIV4) || (mode == M_DIV16);
  wire capture  = evt | mode_chg;

  always_comb begin
    case (mode)
      M_FALL:  evt = fall;
      M_RISE:  evt = rise;
      M_DIV4:  evt = rise && (cnt[1:0] == 2'b11);
      M_DIV16: evt = rise && (cnt == 4'hF);
      default: evt = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      mode_q <= '0;
    end else begin
      sync_q <= {sync_q[1:0], pin_in};
      mode_q <= mode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!cap_on)          cnt <= '0;
    else if (prescaled && rise) cnt <= cnt + 4'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_value <= '0;
      cap_flag  <= 1'b0;
    end else begin
      if (capture) cap_value <= timer_val;
      if (capture)       cap_flag <= 1'b1;
      else if (flag_clr) cap_flag <= 1'b0;
    end
  end

endmodule

// File: rtl/tmr_capture_unit_chk.sv
module tmr_capture_unit_chk #(
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    mode,
  input logic          flag_clr,
  input logic [TW-1:0] cap_value,
  input logic          cap_flag,
  input logic [3:0]    pre_cnt
);

  assert_new_value_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_value != $past(cap_value)) |-> cap_flag);

  assert_flag_fall_needs_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cap_flag) |-> $past(flag_clr));

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_flag && !flag_clr) |=> cap_flag);

  assert_cnt_cleared_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[3:2] != 2'b01) |=> (pre_cnt == 4'd0));

  assert_no_capture_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[3:2] != 2'b01) |=> $stable(cap_value));

endmodule

bind tmr_capture_unit tmr_capture_unit_chk #(.TW(TW)) chk_i (
  .clk(clk), .rst_n(rst_n), .mode(mode), .flag_clr(flag_clr),
  .cap_value(cap_value), .cap_flag(cap_flag), .pre_cnt(cnt)
);

// File: tb/tmr_capture_unit_tb_top.sv
module tmr_capture_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin_in = 1'b0;
  logic [15:0] timer_val = '0;
  logic [3:0]  mode = 4'b0000;
  logic        flag_clr = 1'b0;
  logic [15:0] cap_value;
  logic        cap_flag;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  tmr_capture_unit dut_i (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .timer_val(timer_val),
    .mode(mode), .flag_clr(flag_clr), .cap_value(cap_value), .cap_flag(cap_flag)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] ev, input logic ef);
    n_chk++;
    if (cap_value !== ev || cap_flag !== ef) begin
      n_bad++;
      $display("FAIL %s: value=%h flag=%b expected value=%h flag=%b", req, cap_value, cap_flag, ev, ef);
    end
  endtask

  task automatic clr_flag();
    flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
  endtask

  task automatic set_mode_via_off(input logic [3:0] m);
    mode = 4'b0000; tick(1); mode = m; tick(1);
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      pin_in = 1'b1; tick(2); pin_in = 1'b0; tick(2);
    end
  endtask

  task automatic t_reset();
    chk("R1 reset", 16'h0000, 1'b0);
  endtask

  task automatic t_fall();
    timer_val = 16'h1111;
    set_mode_via_off(4'b0100);
    chk("R11 no capture entering from off", 16'h0000, 1'b0);
    pin_in = 1'b1; tick(3);
    chk("R2 rising edge ignored", 16'h0000, 1'b0);
    pin_in = 1'b0; tick(2);
    chk("R2 not before third edge", 16'h0000, 1'b0);
    tick(1);
    chk("R2 falling capture", 16'h1111, 1'b1);
  endtask

  task automatic t_flag();
    tick(3);
    chk("R8 flag sticky", 16'h1111, 1'b1);
    clr_flag();
    chk("R8 flag cleared", 16'h1111, 1'b0);
  endtask

  task automatic t_rise();
    set_mode_via_off(4'b0101);
    timer_val = 16'h2222;
    pin_in = 1'b1; tick(3);
    chk("R3 rising capture", 16'h2222, 1'b1);
    clr_flag();
    timer_val = 16'h2233;
    pin_in = 1'b0; tick(3);
    chk("R3 falling ignored", 16'h2222, 1'b0);
    pin_in = 1'b1; tick(1);
    timer_val = 16'hAAAA; tick(1);
    pin_in = 1'b0; tick(1);
    chk("R10 second capture pending", 16'hAAAA, 1'b1);
    timer_val = 16'h2244;
    pin_in = 1'b1; tick(3);
    chk("R10 overwrite while flag set", 16'h2244, 1'b1);
    pin_in = 1'b0; tick(3);
  endtask

  task automatic t_div4();
    set_mode_via_off(4'b0110);
    clr_flag();
    timer_val = 16'h4444;
    pulse(3);
    chk("R4 three edges no capture", 16'h2244, 1'b0);
    pulse(1);
    chk("R4 fourth edge captures", 16'h4444, 1'b1);
  endtask

  task automatic t_div16();
    set_mode_via_off(4'b0111);
    clr_flag();
    timer_val = 16'h5555;
    pulse(15);
    chk("R5 fifteen edges no capture", 16'h4444, 1'b0);
    pulse(1);
    chk("R5 sixteenth edge captures", 16'h5555, 1'b1);
  endtask

  task automatic t_switch();
    set_mode_via_off(4'b0111);
    clr_flag();
    pulse(6);
    chk("R7 no capture after six", 16'h5555, 1'b0);
    timer_val = 16'h7777;
    mode = 4'b0110; tick(1);
    chk("R11 spurious capture on direct switch", 16'h7777, 1'b1);
    clr_flag();
    timer_val = 16'h7788;
    pulse(1);
    chk("R7 first edge after switch", 16'h7777, 1'b0);
    pulse(1);
    chk("R7 early capture keeps count", 16'h7788, 1'b1);
  endtask

  task automatic t_off();
    clr_flag();
    pulse(3);
    chk("R4 count not at capture yet", 16'h7788, 1'b0);
    mode = 4'b1000; tick(1);
    timer_val = 16'h9999;
    pulse(4);
    chk("R6 non-capture code ignores pin", 16'h7788, 1'b0);
    mode = 4'b0110; tick(1);
    chk("R11 no spurious from non-capture", 16'h7788, 1'b0);
    pulse(3);
    chk("R6 count cleared by non-capture", 16'h7788, 1'b0);
    pulse(1);
    chk("R6 capture after full count", 16'h9999, 1'b1);
    mode = 4'b0000; tick(1);
    clr_flag();
    pulse(2);
    chk("R6 off ignores pin", 16'h9999, 1'b0);
  endtask

  task automatic t_collide();
    mode = 4'b0101; tick(1);
    timer_val = 16'hBBBB;
    pin_in = 1'b1; tick(2);
    flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
    chk("R9 capture beats clear", 16'hBBBB, 1'b1);
    clr_flag();
    chk("R8 clear alone", 16'hBBBB, 1'b0);
    pin_in = 1'b0; tick(3);
  endtask

  initial begin
    tick(2);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_fall();
    t_flag();
    t_rise();
    t_div4();
    t_div16();
    t_switch();
    t_off();
    t_collide();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule